// File: doc/BRIEF.md
# Stream transfer start synchronizer

This block sits between a streaming data source and a DMA data path and decides when a transfer actually begins. Each transfer is opened by a request that gives the transfer length in beats and a per-transfer "synchronize start" bit. When the build-time enable is on and the bit is set, the block waits for a synchronization flag that is qualified by the source's valid strobe. Beats seen before the flag are dropped. The beat that carries the flag is forwarded as the first beat of the transfer. It targets sources with no back-pressure whose packets span several beats, so that the stored buffer starts on a packet boundary.

The source may be a ready/valid stream or a plain FIFO-style write port that never stalls. For the stream kind, a build-time choice takes the flag from user bit 0 or from a separate sync input. For the FIFO kind, the separate sync input is always the flag. The sync input is taken as already synchronous to the block clock, so no synchronizer stage is inserted. Once the block has triggered, the flag has no effect until the transfer completes. Accepting the next request arms the block again.

Top module: `ssync_top`

## Requirements
- R1: After synchronous reset the block is idle: req_ready is 1, waiting is 0, busy is 0, and out_valid is 0.
- R2: A request accepted with req_sync_start=0 starts at once. The first valid input beat after acceptance is forwarded, and waiting stays 0.
- R3: With the enable on and req_sync_start=1, waiting is 1 from acceptance until the flag beat is consumed. Input beats seen before the flag give out_valid=0 and in_ready=1, so they are drained and discarded.
- R4: The beat that carries the flag is the first beat forwarded, with its data unchanged on out_data.
- R5: Flag source: for the stream kind (SRC_KIND=0) with USER_FLAG=1, the flag is in_user[0]. With USER_FLAG=0 it is sync_in. For the FIFO kind (SRC_KIND=1) it is always sync_in.
- R6: A flag present on a cycle with in_valid=0 does not trigger the transfer.
- R7: After the trigger, further flag values do not change forwarding. All remaining beats of the transfer are forwarded in order.
- R8: A transfer forwards exactly req_beats+1 beats. out_last is 1 on the final beat, and the block then returns to idle with req_ready=1. While idle, the stream kind holds in_ready=0 and out_valid=0.
- R9: With the enable off (SYNC_EN=0), every transfer starts at once whatever req_sync_start is, sync_in and in_user are ignored, and waiting is never 1.
- R10: Stream kind: a forwarded beat with out_ready=0 is held, with in_ready=0. The FIFO kind holds in_ready=1 at all times, and each forwarded beat counts on its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request strobe |
| req_ready | output | 1 | Request accepted when high with req_valid (idle) |
| req_sync_start | input | 1 | Hold this transfer until the flag is seen |
| req_beats | input | LEN_W | Transfer length in beats minus one |
| in_valid | input | 1 | Source data valid (write enable for the FIFO kind) |
| in_ready | output | 1 | Source may advance |
| in_data | input | DATA_W | Source data |
| in_user | input | USER_W | Source sideband, bit 0 may carry the flag |
| sync_in | input | 1 | Separate synchronization flag |
| out_valid | output | 1 | Forwarded beat valid |
| out_ready | input | 1 | Downstream accepts (stream kind only) |
| out_data | output | DATA_W | Forwarded data |
| out_last | output | 1 | Final beat of the transfer |
| waiting | output | 1 | Armed and waiting for the flag |
| busy | output | 1 | A transfer is open |

## Verification
The hard situation to reach is one where the flag sits on one source while the other source is quiet. The selection logic is then the only thing that separates a triggered instance from one that keeps waiting. The bench drives four builds from the same stimulus (user-bit flag, sync-port flag, FIFO kind, feature off). It raises in_user[0] alone, then sync_in alone, with flags first on invalid cycles, so that the builds diverge beat by beat. A separate pass stalls out_ready on the very flag beat. This shows that the stream kind holds the flag beat while the FIFO kind takes it at once.

// File: rtl/ssync_pkg.sv
package ssync_pkg;

    localparam int SRC_STREAM = 0;
    localparam int SRC_FIFO   = 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } ssync_state_e;

    typedef struct packed {
        logic fwd_en;
        logic drain;
    } gate_t;

    function automatic ssync_state_e start_state(input logic enable, input logic want_sync);
        return (enable && want_sync) ? ST_WAIT : ST_RUN;
    endfunction

    function automatic gate_t gate_of(input ssync_state_e st, input logic flag_hit);
        gate_t g;
        g.fwd_en = (st == ST_RUN) || (st == ST_WAIT && flag_hit);
        g.drain  = (st == ST_WAIT) && !flag_hit;
        return g;
    endfunction

endpackage

// File: rtl/ssync_flag_sel.sv
module ssync_flag_sel
    import ssync_pkg::*;
#(
    parameter int SRC_KIND  = SRC_STREAM,
    parameter int USER_FLAG = 1
) (
    input  logic in_valid,
    input  logic user_bit0,
    input  logic sync_in,
    output logic flag_hit
);

    logic raw_flag;

    generate
        if (SRC_KIND == SRC_STREAM && USER_FLAG != 0) begin : g_user
            assign raw_flag = user_bit0;
        end else begin : g_port
            assign raw_flag = sync_in;
        end
    endgenerate

    assign flag_hit = in_valid && raw_flag;

endmodule

// File: rtl/ssync_beat_ctr.sv
module ssync_beat_ctr #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] load_val,
    input  logic             dec,
    output logic             at_last
);

    logic [LEN_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (dec && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign at_last = (remain == '0);

    // R8: count only moves on load or a forwarded beat
    a_r8_count_stable: assert property (@(posedge clk) disable iff (rst)
        (!load && !dec) |=> $stable(remain));

endmodule

// File: rtl/ssync_ctrl.sv
module ssync_ctrl
    import ssync_pkg::*;
#(
    parameter int SRC_KIND = SRC_STREAM,
    parameter int SYNC_EN  = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic req_sync,
    input  logic flag_hit,
    input  logic in_valid,
    input  logic out_ready,
    input  logic last_beat,
    output logic req_ready,
    output logic req_fire,
    output logic in_ready,
    output logic out_valid,
    output logic beat_fire,
    output logic waiting,
    output logic busy
);

    localparam logic IS_FIFO = (SRC_KIND == SRC_FIFO);
    localparam logic ENABLE  = (SYNC_EN != 0);

    ssync_state_e state, state_nx;
    gate_t        gate;

    assign gate      = gate_of(state, flag_hit);
    assign req_ready = (state == ST_IDLE);
    assign req_fire  = req_valid && req_ready;
    assign out_valid = in_valid && gate.fwd_en;
    assign beat_fire = out_valid && (out_ready || IS_FIFO);
    assign waiting   = (state == ST_WAIT);
    assign busy      = (state != ST_IDLE);

    generate
        if (SRC_KIND == SRC_FIFO) begin : g_fifo_rdy
            assign in_ready = 1'b1;
        end else begin : g_strm_rdy
            assign in_ready = gate.drain || (gate.fwd_en && out_ready);
        end
    endgenerate

    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (req_fire) state_nx = start_state(ENABLE, req_sync);
            ST_WAIT: if (beat_fire) state_nx = last_beat ? ST_IDLE : ST_RUN;
            ST_RUN:  if (beat_fire && last_beat) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // R2: an accepted request opens a transfer
    a_r2_req_opens: assert property (@(posedge clk) disable iff (rst)
        req_fire |=> busy);

    // R8: the final forwarded beat closes the transfer
    a_r8_last_closes: assert property (@(posedge clk) disable iff (rst)
        (beat_fire && last_beat) |=> req_ready);

    // R7: once running, the block never goes back to waiting
    a_r7_no_rearm: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) |=> (state != ST_WAIT));

    generate
        if (SYNC_EN == 0) begin : g_off_chk
            // R9: with the feature off the block never waits
            a_r9_never_wait: assert property (@(posedge clk) disable iff (rst)
                !waiting);
        end
    endgenerate

endmodule

// File: rtl/ssync_top.sv
module ssync_top
    import ssync_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int USER_W    = 2,
    parameter int LEN_W     = 4,
    parameter int SRC_KIND  = SRC_STREAM,
    parameter int USER_FLAG = 1,
    parameter int SYNC_EN   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_sync_start,
    input  logic [LEN_W-1:0]  req_beats,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [USER_W-1:0] in_user,
    input  logic              sync_in,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              waiting,
    output logic              busy
);

    logic flag_hit;
    logic req_fire;
    logic beat_fire;
    logic last_beat;
    logic unused_sideband;

    assign unused_sideband = ^{in_user, sync_in, out_ready};

    ssync_flag_sel #(
        .SRC_KIND  (SRC_KIND),
        .USER_FLAG (USER_FLAG)
    ) u_flag (
        .in_valid  (in_valid),
        .user_bit0 (in_user[0]),
        .sync_in   (sync_in),
        .flag_hit  (flag_hit)
    );

    ssync_beat_ctr #(
        .LEN_W (LEN_W)
    ) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load     (req_fire),
        .load_val (req_beats),
        .dec      (beat_fire),
        .at_last  (last_beat)
    );

    ssync_ctrl #(
        .SRC_KIND (SRC_KIND),
        .SYNC_EN  (SYNC_EN)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_sync  (req_sync_start),
        .flag_hit  (flag_hit),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .last_beat (last_beat),
        .req_ready (req_ready),
        .req_fire  (req_fire),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .beat_fire (beat_fire),
        .waiting   (waiting),
        .busy      (busy)
    );

    assign out_data = in_data;
    assign out_last = out_valid && last_beat;

    // R3: nothing is forwarded while waiting unless the flag is present
    a_r3_no_early_beat: assert property (@(posedge clk) disable iff (rst)
        (waiting && !flag_hit) |-> !out_valid);

    // R3: discarded beats are drained, not stalled
    a_r3_drain_ready: assert property (@(posedge clk) disable iff (rst)
        (waiting && !flag_hit) |-> in_ready);

    // R4: the flag beat is forwarded while still armed
    a_r4_flag_beat_fwd: assert property (@(posedge clk) disable iff (rst)
        (waiting && flag_hit) |-> out_valid);

    generate
        if (SRC_KIND == SRC_STREAM) begin : g_bp_chk
            // R10: a stalled forwarded beat is held at the source
            a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
                (out_valid && !out_ready) |-> !in_ready);
        end
    endgenerate

endmodule

// File: tb/tb_ssync_top.sv
module tb_ssync_top;

    localparam int DW = 8;
    localparam int UW = 2;
    localparam int LW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          req_valid = 0, req_sync = 0;
    logic [LW-1:0] req_beats = '0;
    logic          in_valid = 0, sync_in = 0, out_ready = 1;
    logic [DW-1:0] in_data = '0;
    logic [UW-1:0] in_user = '0;

    logic          rr [4];
    logic          ir [4];
    logic          ov [4];
    logic [DW-1:0] od [4];
    logic          ol [4];
    logic          wt [4];
    logic          bz [4];

    int checks = 0;
    int errors = 0;

    ssync_top #(.DATA_W(DW), .USER_W(UW), .LEN_W(LW), .SRC_KIND(0), .USER_FLAG(1), .SYNC_EN(1)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rr[0]), .req_sync_start(req_sync),
        .req_beats(req_beats), .in_valid(in_valid), .in_ready(ir[0]), .in_data(in_data),
        .in_user(in_user), .sync_in(sync_in), .out_valid(ov[0]), .out_ready(out_ready),
        .out_data(od[0]), .out_last(ol[0]), .waiting(wt[0]), .busy(bz[0]));

    ssync_top #(.DATA_W(DW), .USER_W(UW), .LEN_W(LW), .SRC_KIND(0), .USER_FLAG(0), .SYNC_EN(1)) dut_b (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rr[1]), .req_sync_start(req_sync),
        .req_beats(req_beats), .in_valid(in_valid), .in_ready(ir[1]), .in_data(in_data),
        .in_user(in_user), .sync_in(sync_in), .out_valid(ov[1]), .out_ready(out_ready),
        .out_data(od[1]), .out_last(ol[1]), .waiting(wt[1]), .busy(bz[1]));

    ssync_top #(.DATA_W(DW), .USER_W(UW), .LEN_W(LW), .SRC_KIND(1), .USER_FLAG(1), .SYNC_EN(1)) dut_c (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rr[2]), .req_sync_start(req_sync),
        .req_beats(req_beats), .in_valid(in_valid), .in_ready(ir[2]), .in_data(in_data),
        .in_user(in_user), .sync_in(sync_in), .out_valid(ov[2]), .out_ready(out_ready),
        .out_data(od[2]), .out_last(ol[2]), .waiting(wt[2]), .busy(bz[2]));

    ssync_top #(.DATA_W(DW), .USER_W(UW), .LEN_W(LW), .SRC_KIND(0), .USER_FLAG(1), .SYNC_EN(0)) dut_d (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(rr[3]), .req_sync_start(req_sync),
        .req_beats(req_beats), .in_valid(in_valid), .in_ready(ir[3]), .in_data(in_data),
        .in_user(in_user), .sync_in(sync_in), .out_valid(ov[3]), .out_ready(out_ready),
        .out_data(od[3]), .out_last(ol[3]), .waiting(wt[3]), .busy(bz[3]));

    task automatic chk(input string req, input string what, input int idx, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s inst%0d: actual %0d expected %0d", req, what, idx, act, exp);
        end
    endtask

    task automatic beat(input logic v, input int d, input logic u, input logic s);
        @(negedge clk);
        in_valid = v; in_data = DW'(d); in_user = {1'b0, u}; sync_in = s;
        #1;
    endtask

    task automatic request(input logic sy, input int len);
        @(negedge clk);
        in_valid = 0; req_valid = 1; req_sync = sy; req_beats = LW'(len);
        #1;
        for (int i = 0; i < 4; i++) chk("R8", "req_ready before request", i, rr[i], 1);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic all_idle(input string req);
        beat(0, 0, 0, 0);
        for (int i = 0; i < 4; i++) begin
            chk(req, "req_ready idle", i, rr[i], 1);
            chk(req, "busy idle", i, bz[i], 0);
            chk(req, "waiting idle", i, wt[i], 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            chk("R1", "req_ready", i, rr[i], 1);
            chk("R1", "waiting", i, wt[i], 0);
            chk("R1", "busy", i, bz[i], 0);
            chk("R1", "out_valid", i, ov[i], 0);
        end

        // Sweep: junk beats before flag x transfer length (R3 R4 R7 R8 R9)
        for (int nj = 0; nj < 4; nj++) begin
            for (int len = 0; len < 4; len++) begin
                request(1, len);
                for (int k = 0; k <= nj + len; k++) begin
                    logic fl;
                    fl = (k == nj) || (k == nj + 2); // R7: second flag must be ignored
                    beat(1, k + 16 * nj, fl, fl);
                    for (int i = 0; i < 3; i++) begin
                        chk(k < nj ? "R3" : "R4", "out_valid", i, ov[i], (k >= nj) ? 1 : 0);
                        if (k >= nj) chk("R7", "out_data", i, od[i], k + 16 * nj);
                        chk("R8", "out_last", i, ol[i], (k == nj + len) ? 1 : 0);
                        chk("R3", "waiting", i, wt[i], (k <= nj) ? 1 : 0);
                        chk("R3", "in_ready", i, ir[i], 1);
                    end
                    chk("R9", "off out_valid", 3, ov[3], (k <= len) ? 1 : 0);
                    chk("R9", "off waiting", 3, wt[3], 0);
                    chk("R8", "off out_last", 3, ol[3], (k == len) ? 1 : 0);
                    chk("R8", "off in_ready", 3, ir[3], (k <= len) ? 1 : 0);
                end
                all_idle("R8");
            end
        end

        // Flag source selection and valid qualification (R5 R6 R9)
        request(1, 1);
        beat(0, 9, 1, 1);
        for (int i = 0; i < 3; i++) chk("R6", "waiting after unqualified flag", i, wt[i], 1);
        beat(0, 9, 0, 0);
        for (int i = 0; i < 3; i++) chk("R6", "still waiting", i, wt[i], 1);
        beat(1, 0, 1, 0);
        chk("R5", "user flag triggers", 0, ov[0], 1);
        chk("R5", "sync-port ignores user", 1, ov[1], 0);
        chk("R5", "fifo ignores user", 2, ov[2], 0);
        chk("R9", "off forwards", 3, ov[3], 1);
        beat(1, 1, 0, 0);
        chk("R8", "user inst last", 0, ol[0], 1);
        chk("R5", "sync-port waiting", 1, wt[1], 1);
        chk("R5", "fifo waiting", 2, wt[2], 1);
        chk("R8", "off last", 3, ol[3], 1);
        beat(1, 2, 0, 1);
        chk("R8", "user inst idle", 0, ov[0], 0);
        chk("R8", "user inst idle stalls", 0, ir[0], 0);
        chk("R5", "sync-port triggers", 1, ov[1], 1);
        chk("R4", "sync-port first data", 1, od[1], 2);
        chk("R5", "fifo triggers", 2, ov[2], 1);
        chk("R4", "fifo first data", 2, od[2], 2);
        chk("R9", "off ignores sync", 3, ov[3], 0);
        beat(1, 3, 0, 0);
        chk("R8", "sync-port last", 1, ol[1], 1);
        chk("R8", "fifo last", 2, ol[2], 1);
        chk("R7", "sync-port data", 1, od[1], 3);
        all_idle("R5");

        // Stall on the flag beat (R10)
        request(1, 0);
        out_ready = 0;
        beat(1, 5, 1, 1);
        chk("R10", "stream out_valid on stall", 0, ov[0], 1);
        chk("R10", "stream holds source", 0, ir[0], 0);
        chk("R10", "stream still waiting", 0, wt[0], 1);
        chk("R10", "fifo always ready", 2, ir[2], 1);
        chk("R10", "fifo forwards", 2, ov[2], 1);
        @(negedge clk);
        out_ready = 1;
        #1;
        chk("R10", "stream released", 0, ov[0], 1);
        chk("R10", "stream ready", 0, ir[0], 1);
        chk("R10", "stream last", 0, ol[0], 1);
        chk("R10", "stream data", 0, od[0], 5);
        chk("R10", "fifo done", 2, ov[2], 0);
        all_idle("R10");

        // No sync bit: immediate start (R2)
        request(0, 2);
        for (int k = 0; k < 3; k++) begin
            beat(1, 40 + k, 0, 0);
            for (int i = 0; i < 4; i++) begin
                chk("R2", "out_valid", i, ov[i], 1);
                chk("R2", "out_data", i, od[i], 40 + k);
                chk("R2", "waiting", i, wt[i], 0);
            end
        end
        all_idle("R2");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule